// File: doc/BRIEF.md
# Sequence Self-Test Checker

This block decides whether a buffer of 64-bit words, captured from a random number source run in a known health-check mode, contains the expected pseudo-random sequence. Software or a capture engine first fills the buffer through a simple write port. A start pulse then makes the checker walk a left-shifting Galois LFSR, beginning at a fixed seed. For each LFSR value it counts how many buffer words equal that value, leaving out slot 0.

The matches are summed across all passes. The check ends with pass as soon as the running sum reaches a goal. It ends with fail when the allowed number of passes runs out first. The result and the number of passes used stay on the outputs until the next start.

The checker compares one buffer word per clock, so each pass takes DEPTH-1 cycles.

Top module: `seq_selftest`

## Requirements
- R1: After reset, done, pass and iterCount are all 0.
- R2: Buffer slot 0 (write address 0) is never compared; only slots 1 to DEPTH-1 can add to the match total.
- R3: A start pulse loads SEED as the current value. After each pass that does not end the check, the value advances exactly one step: shift left by one bit, then XOR with POLY if the bit shifted out of bit 63 was 1.
- R4: The match count of every pass is added to a running total that is kept across passes. Start clears the total.
- R5: When the total reaches MATCH_GOAL at the end of a pass, done and pass go to 1, and iterCount equals the number of passes made, counting the one that ended the check.
- R6: When ITER_LIMIT passes complete without reaching the goal, done goes to 1 with pass at 0, and iterCount equals ITER_LIMIT.
- R7: One slot is compared per clock. done rises exactly P*(DEPTH-1) clock edges after the edge that samples start, where P is the number of passes made. While the check runs, iterCount shows the number of completed passes.
- R8: done, pass and iterCount hold their values until the next start. A start clears done and pass.
- R9: A write (wrEn=1; wrAddr selects the slot, wrData is the word) is ignored while a check is running. It is accepted at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Buffer write strobe |
| wrAddr | input | $clog2(DEPTH) | Slot to write |
| wrData | input | 64 | Word to store |
| start | input | 1 | Begin a check |
| done | output | 1 | Check finished |
| pass | output | 1 | Goal reached (valid with done) |
| iterCount | output | $clog2(ITER_LIMIT+1) | Passes completed |

## Verification
The assertions assume that DEPTH is at least 2 and that MATCH_GOAL is at least 1, so a pass can only end on its last slot. They also assume start is a single-cycle pulse. The stimulus sends start for one clock only and writes the buffer only while the checker is idle, except in one deliberate case. That case writes a matching word in the middle of a run, and the expected result is computed from the buffer as it stood before the run. Buffer contents are chosen so that the pass or fail decision falls on the first pass, on a middle pass and on the last allowed pass.

// File: rtl/seq_selftest_pkg.sv
package seq_selftest_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic clear;    // reload seed, reset total and slot index
    logic compare;  // compare current slot this cycle
    logic advance;  // step the LFSR value at end of pass
    logic wrAllow;  // buffer writes permitted
  } stepCtl_t;
endpackage

// File: rtl/seq_selftest_dp.sv
module seq_selftest_dp
  import seq_selftest_pkg::*;
#(
  parameter int          DEPTH      = 8,
  parameter logic [63:0] SEED       = 64'h1,
  parameter logic [63:0] POLY       = 64'h1,
  parameter int          MATCH_GOAL = 3,
  localparam int         IDX_W      = $clog2(DEPTH),
  localparam int         CNT_W      = $clog2(MATCH_GOAL + DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  stepCtl_t         ctl,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrAddr,
  input  logic [63:0]      wrData,
  output logic             lastSlot,
  output logic             goalMet
);
  localparam logic [IDX_W-1:0] FIRST_IDX = IDX_W'(1);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(DEPTH - 1);

  logic [63:0]      testMem [DEPTH];
  logic [63:0]      curValue;
  logic [63:0]      nextValue;
  logic [IDX_W-1:0] slotIdx;
  logic [CNT_W-1:0] matchTotal;
  logic [CNT_W-1:0] totalWithHit;
  logic             hit;

  always_ff @(posedge clk) begin
    if (wrEn && ctl.wrAllow) testMem[wrAddr] <= wrData;
  end

  assign hit          = ctl.compare && (testMem[slotIdx] == curValue);
  assign totalWithHit = matchTotal + CNT_W'(hit);
  assign goalMet      = totalWithHit >= CNT_W'(MATCH_GOAL);
  assign lastSlot     = slotIdx == LAST_IDX;
  assign nextValue    = {curValue[62:0], 1'b0} ^ (curValue[63] ? POLY : 64'h0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curValue   <= SEED;
      slotIdx    <= FIRST_IDX;
      matchTotal <= '0;
    end else if (ctl.clear) begin
      curValue   <= SEED;
      slotIdx    <= FIRST_IDX;
      matchTotal <= '0;
    end else begin
      if (ctl.compare) begin
        matchTotal <= totalWithHit;
        slotIdx    <= lastSlot ? FIRST_IDX : slotIdx + FIRST_IDX;
      end
      if (ctl.advance) curValue <= nextValue;
    end
  end

  AST_SLOT0_SKIPPED: assert property (@(posedge clk) disable iff (!rstN)
    slotIdx != '0);  // R2
  AST_VALUE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.advance && !ctl.clear) |=> $stable(curValue));  // R3
  AST_TOTAL_MONOTONIC: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.clear |=> matchTotal >= $past(matchTotal));  // R4
endmodule

// File: rtl/seq_selftest_ctl.sv
module seq_selftest_ctl
  import seq_selftest_pkg::*;
#(
  parameter int  ITER_LIMIT = 16,
  localparam int ITER_W     = $clog2(ITER_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              lastSlot,
  input  logic              goalMet,
  output stepCtl_t          ctl,
  output logic              done,
  output logic              pass,
  output logic [ITER_W-1:0] iterCount
);
  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_FIN} chkState_t;

  chkState_t   state;
  logic        scanning;
  logic        passEnd;
  logic        limitHit;
  logic        passReg;
  logic [ITER_W-1:0] iterReg;

  assign scanning = state == ST_SCAN;
  assign passEnd  = scanning && lastSlot;
  assign limitHit = (iterReg + ITER_W'(1)) == ITER_W'(ITER_LIMIT);

  always_comb begin
    ctl         = '0;
    ctl.clear   = start && !scanning;
    ctl.compare = scanning;
    ctl.advance = passEnd && !goalMet && !limitHit;
    ctl.wrAllow = !scanning;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      passReg <= 1'b0;
      iterReg <= '0;
    end else if (start && !scanning) begin
      state   <= ST_SCAN;
      passReg <= 1'b0;
      iterReg <= '0;
    end else if (passEnd) begin
      iterReg <= iterReg + ITER_W'(1);
      if (goalMet || limitHit) begin
        state   <= ST_FIN;
        passReg <= goalMet;
      end
    end
  end

  assign done      = state == ST_FIN;
  assign pass      = passReg;
  assign iterCount = iterReg;

  AST_PASS_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    pass |-> done);  // R5
  AST_ITER_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    iterCount <= ITER_W'(ITER_LIMIT));  // R6
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> (done && $stable(pass) && $stable(iterCount)));  // R8
  AST_NO_WRITE_WHILE_SCAN: assert property (@(posedge clk) disable iff (!rstN)
    ctl.compare |-> !ctl.wrAllow);  // R9
  AST_FAIL_AT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) && !pass |-> iterCount == ITER_W'(ITER_LIMIT));  // R6
endmodule

// File: rtl/seq_selftest.sv
module seq_selftest
  import seq_selftest_pkg::*;
#(
  parameter int          DEPTH      = 8,
  parameter logic [63:0] SEED       = 64'hC0FF_EE12_3456_789B,
  parameter logic [63:0] POLY       = (64'h1 << 61) | (64'h1 << 57) | (64'h1 << 56) |
                                      (64'h1 << 52) | (64'h1 << 51) | (64'h1 << 50) |
                                      (64'h1 << 48) | (64'h1 << 47) | (64'h1 << 46) |
                                      (64'h1 << 43) | (64'h1 << 42) | (64'h1 << 41) |
                                      (64'h1 << 39) | (64'h1 << 38) | (64'h1 << 37) |
                                      (64'h1 << 35) | (64'h1 << 32) | (64'h1 << 28) |
                                      (64'h1 << 25) | (64'h1 << 22) | (64'h1 << 21) |
                                      (64'h1 << 17) | (64'h1 << 15) | (64'h1 << 13) |
                                      (64'h1 << 12) | (64'h1 << 11) | (64'h1 << 7) |
                                      (64'h1 << 5)  | (64'h1 << 1)  | 64'h1,
  parameter int          MATCH_GOAL = 3,
  parameter int          ITER_LIMIT = 16,
  localparam int         IDX_W      = $clog2(DEPTH),
  localparam int         ITER_W     = $clog2(ITER_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [63:0]       wrData,
  input  logic              start,
  output logic              done,
  output logic              pass,
  output logic [ITER_W-1:0] iterCount
);
  stepCtl_t ctl;
  logic     lastSlot;
  logic     goalMet;

  seq_selftest_ctl #(.ITER_LIMIT(ITER_LIMIT)) i_ctl (
    .clk(clk), .rstN(rstN), .start(start), .lastSlot(lastSlot),
    .goalMet(goalMet), .ctl(ctl), .done(done), .pass(pass),
    .iterCount(iterCount)
  );

  seq_selftest_dp #(
    .DEPTH(DEPTH), .SEED(SEED), .POLY(POLY), .MATCH_GOAL(MATCH_GOAL)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .lastSlot(lastSlot), .goalMet(goalMet)
  );
endmodule

// File: tb/test_seq_selftest.sv
module test_seq_selftest;
  localparam int          DEPTH = 8;
  localparam int          GOAL  = 3;
  localparam int          LIMIT = 16;
  localparam logic [63:0] SEED  = 64'hC0FF_EE12_3456_789B;
  localparam logic [63:0] POLY  = 64'hB0E3_9B9D_AD10_20A5 ^ 64'h0;
  localparam int          IDX_W = $clog2(DEPTH);
  localparam int          ITER_W = $clog2(LIMIT + 1);

  logic clk = 0, rstN = 0, wrEn = 0, start = 0;
  logic [IDX_W-1:0]  wrAddr = '0;
  logic [63:0]       wrData = '0;
  logic done, pass;
  logic [ITER_W-1:0] iterCount;

  int nTests = 0, nFails = 0;
  logic [63:0] shadow [DEPTH];

  always #4 clk = ~clk;

  seq_selftest #(.DEPTH(DEPTH), .SEED(SEED), .POLY(POLY),
                 .MATCH_GOAL(GOAL), .ITER_LIMIT(LIMIT)) i_seq_selftest (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .start(start), .done(done), .pass(pass), .iterCount(iterCount));

  function automatic logic [63:0] stepN(input int n);
    logic [63:0] v = SEED;
    for (int k = 0; k < n; k++) begin
      logic msb = v[63];
      v = v << 1;
      if (msb) v = v ^ POLY;
    end
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic writeSlot(input int slot, input logic [63:0] val);
    @(negedge clk);
    wrEn = 1; wrAddr = IDX_W'(slot); wrData = val;
    shadow[slot] = val;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic fillZero();
    for (int s = 0; s < DEPTH; s++) writeSlot(s, 64'h0);
  endtask

  // run a check; injectSlot >= 0 writes a matching word mid-run (must be ignored)
  task automatic runCheck(input string req, input int injectSlot);
    int passes = LIMIT, total = 0, expDone, j;
    logic expPass = 0;
    for (int p = 0; p < LIMIT; p++) begin
      logic [63:0] v = stepN(p);
      for (int s = 1; s < DEPTH; s++) if (shadow[s] == v) total++;
      if (total >= GOAL) begin passes = p + 1; expPass = 1; break; end
    end
    expDone = passes * (DEPTH - 1);
    @(negedge clk);
    start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    j = 0;
    while (1) begin
      if (j == 2 && injectSlot >= 0) begin
        wrEn = 1; wrAddr = IDX_W'(injectSlot); wrData = SEED;
      end else wrEn = 0;
      check({req, " R7 done timing"}, 32'(done), 32'(j == expDone));
      check({req, " R7 iterCount"}, 32'(iterCount), 32'(j / (DEPTH - 1)));
      if (j == expDone) break;
      check({req, " R8 pass low while running"}, 32'(pass), 0);
      @(negedge clk);
      j++;
    end
    wrEn = 0;
    check({req, expPass ? " R5 pass" : " R6 fail"}, 32'(pass), 32'(expPass));
    check({req, " R5/R6 passes used"}, 32'(iterCount), 32'(passes));
    repeat (3) @(negedge clk);
    check({req, " R8 done held"}, 32'(done), 1);
    check({req, " R8 pass held"}, 32'(pass), 32'(expPass));
    check({req, " R8 iterCount held"}, 32'(iterCount), 32'(passes));
  endtask

  initial begin
    #300000;
    nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 done", 32'(done), 0);
    check("R1 pass", 32'(pass), 0);
    check("R1 iterCount", 32'(iterCount), 0);
    rstN = 1;
    fillZero();
    runCheck("R6 empty buffer", -1);
    // first pass matches three times, R3 seed load
    writeSlot(1, SEED); writeSlot(2, SEED); writeSlot(3, SEED);
    runCheck("R3 seed match", -1);
    // slot 0 holds seed but must not count: only two matches -> fail (R2)
    fillZero();
    writeSlot(0, SEED); writeSlot(1, SEED); writeSlot(5, SEED);
    runCheck("R2 slot0 skipped", -1);
    // accumulate across passes, R4, R3 stepping
    fillZero();
    writeSlot(7, stepN(0)); writeSlot(4, stepN(1)); writeSlot(2, stepN(2));
    runCheck("R4 accumulate", -1);
    // goal reached on the last allowed pass
    fillZero();
    writeSlot(1, stepN(LIMIT - 1)); writeSlot(2, stepN(LIMIT - 1));
    writeSlot(3, stepN(LIMIT - 1));
    runCheck("R5 last pass", -1);
    // one step too far -> fail
    fillZero();
    writeSlot(1, stepN(LIMIT)); writeSlot(2, stepN(LIMIT)); writeSlot(3, stepN(LIMIT));
    runCheck("R6 beyond limit", -1);
    // mid-run write ignored: two seeds present, injected third must not count
    fillZero();
    writeSlot(1, SEED); writeSlot(2, SEED);
    runCheck("R9 write during run", 6);
    // slot 6 must still be zero: add one seed at slot 3 -> exactly three matches
    writeSlot(3, SEED);
    runCheck("R9 slot unchanged", -1);
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule